// File: doc/BRIEF.md
# UART Channel Interrupt Aggregator

This block gathers interrupt causes from a group of UART channels (16 by default) and folds them into a single interrupt line. Each channel keeps a status word that mixes live modem-line levels with sticky event flags: receive data pending, receive overrun, transmit FIFO empty, and change flags for the four modem lines. Sticky flags are cleared by writing 1 to them. Live levels ignore writes, so software can write back the word it has just read to acknowledge exactly the events it saw. A per-channel enable word selects which causes raise the channel's pending bit.

The group keeps a pending vector with one bit per channel and a channel mask in which a set bit silences that channel. A control word holds a group enable. The interrupt output is high only when the group enable is set and at least one unmasked channel is pending. The raw modem lines are asynchronous. Each passes through a synchronizer of configurable depth before its edges are detected.

Software reaches every word through a simple single-cycle register port. The address holds a region bit on top, then the channel index, then a word select in bit 0. Reads are combinational. Writes take effect at the clock edge.

Top module: `uart_irq_aggr`

## Requirements
- R1: After reset every sticky flag and every enable bit is 0, the channel mask reads all ones for the implemented channels, the group enable is 0 and `irq_o` is low.
- R2: A receive event pulse sets status bit 0 of its channel, and the bit stays set until a write of 1 to bit 0 clears it. When an event and a clearing write meet in the same cycle, the bit ends up set.
- R3: An overrun event pulse sets status bit 13, which is cleared by writing 1 to it. Overrun never raises the channel's pending bit.
- R4: Status bits 3, 4, 5 and 6 show the synchronized levels of DCD, DSR, CTS and RI. Writes to these bits, and to any status bit that is not a sticky flag, have no effect.
- R5: Any edge on a synchronized modem line sets its change flag: bit 16 for DSR, bit 17 for CTS, bit 18 for DCD and bit 22 for RI. Each flag is cleared by writing 1 to it.
- R6: A transmit-empty pulse sets status bit 25 only while enable bit 19 is set. Clearing enable bit 19 also clears bit 25.
- R7: The enable word implements bit 0 (modem changes), bit 2 (receive data) and bit 19 (transmit empty). All other enable bits read 0.
- R8: A channel's pending bit is (bit0 AND en2) OR (bit25 AND en19) OR (any change flag AND en0). The pending vector can be read at group word select 0, with bit n for channel n.
- R9: At group word select 1 the channel mask can be read and written. A 1 bit keeps that channel from driving `irq_o`.
- R10: The group enable is bit 20 of the control word at group word select 2. `irq_o` = group enable AND (any pending AND NOT mask).
- R11: Address bit ADDR_W-1 selects the region. When it is 0, bits CH_IDX_W..1 give the channel and bit 0 selects status (0) or enable (1). When it is 1, bits 1..0 select the group word. Writes to the pending vector are ignored, group word select 3 reads 0, and a status write leaves the enable word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| rx_evt_i | input | NUM_CH | Receive-data event pulses, one per channel |
| tx_evt_i | input | NUM_CH | Transmit-empty event pulses |
| ovr_evt_i | input | NUM_CH | Receive overrun event pulses |
| dcd_i | input | NUM_CH | Raw carrier-detect lines |
| dsr_i | input | NUM_CH | Raw data-set-ready lines |
| cts_i | input | NUM_CH | Raw clear-to-send lines |
| ri_i | input | NUM_CH | Raw ring-indicator lines |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The bench uses the defaults: NUM_CH = 16 and a two-stage synchronizer. With 16 channels the channel index uses the full 4-bit field, so every address decodes to a real channel, and mask patterns can leave any single channel, or none, unmasked. With two synchronizer stages a modem edge reaches the status word three cycles after it is driven, and the bench's settling waits are sized to that. Random events, line toggles, enable, mask and control writes, and clearing writes are mixed with directed cases: a set and a clear in the same cycle, writes to live bits and to the pending vector, and turning the transmit enable off and back on.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned MODEM_N  = 4;   // index 0 dcd, 1 dsr, 2 cts, 3 ri

   // status word positions
   localparam int unsigned ST_RX    = 0;
   localparam int unsigned LIVE_LSB = 3;
   localparam int unsigned ST_OVR   = 13;
   localparam int unsigned ST_TXE   = 25;

   // enable word positions
   localparam int unsigned EN_MS    = 0;
   localparam int unsigned EN_RX    = 2;
   localparam int unsigned EN_TX    = 19;

   // control word position
   localparam int unsigned CTRL_GEN = 20;

   typedef enum logic [1:0] {
      GRP_PEND = 2'd0,
      GRP_MASK = 2'd1,
      GRP_CTRL = 2'd2
   } grp_sel_e;

   // change-flag position for modem line index
   function automatic int unsigned chg_pos(input int unsigned idx);
      case (idx)
         0:       return 18;
         1:       return 16;
         2:       return 17;
         default: return 22;
      endcase
   endfunction
endpackage

// File: rtl/uirq_sync.sv
module uirq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "uirq_sync: STAGES must be at least 2");
      assert (W >= 1)      else $fatal(1, "uirq_sync: W must be at least 1");
   end

   logic [W-1:0] ff_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) ff_q[s] <= '0;
               else         ff_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) ff_q[s] <= '0;
               else         ff_q[s] <= ff_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uirq_chan.sv
module uirq_chan
   import uart_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rx_evt_i,
   input  logic               tx_evt_i,
   input  logic               ovr_evt_i,
   input  logic [MODEM_N-1:0] line_i,
   input  logic               st_wr_i,
   input  logic               en_wr_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [REG_W-1:0]   status_o,
   output logic [REG_W-1:0]   enable_o,
   output logic               pend_o
);
   logic [MODEM_N-1:0] lvl, lvl_d, lvl_edge, chg_q;
   logic rx_q, ovr_q, tx_q;
   logic en_ms_q, en_rx_q, en_tx_q;

   uirq_sync #(.W(MODEM_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_i),
      .q_o   (lvl)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_d <= '0;
      else         lvl_d <= lvl;
   end

   assign lvl_edge = lvl ^ lvl_d;

   genvar i;
   generate
      for (i = 0; i < MODEM_N; i++) begin : g_chg
         localparam int unsigned POS = chg_pos(i);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chg_q[i] <= 1'b0;
            else         chg_q[i] <= lvl_edge[i] | (chg_q[i] & ~(st_wr_i & wdata_i[POS]));
         end
      end
   endgenerate

   // sticky events: a set in the same cycle as a clear wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q  <= 1'b0;
         ovr_q <= 1'b0;
         tx_q  <= 1'b0;
      end else begin
         rx_q  <= rx_evt_i  | (rx_q  & ~(st_wr_i & wdata_i[ST_RX]));
         ovr_q <= ovr_evt_i | (ovr_q & ~(st_wr_i & wdata_i[ST_OVR]));
         tx_q  <= en_tx_q & (tx_evt_i | (tx_q & ~(st_wr_i & wdata_i[ST_TXE])));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_ms_q <= 1'b0;
         en_rx_q <= 1'b0;
         en_tx_q <= 1'b0;
      end else if (en_wr_i) begin
         en_ms_q <= wdata_i[EN_MS];
         en_rx_q <= wdata_i[EN_RX];
         en_tx_q <= wdata_i[EN_TX];
      end
   end

   always_comb begin
      status_o = '0;
      status_o[ST_RX] = rx_q;
      status_o[LIVE_LSB +: MODEM_N] = lvl;
      status_o[ST_OVR] = ovr_q;
      status_o[ST_TXE] = tx_q & en_tx_q;
      for (int k = 0; k < MODEM_N; k++) status_o[chg_pos(k)] = chg_q[k];
   end

   always_comb begin
      enable_o = '0;
      enable_o[EN_MS] = en_ms_q;
      enable_o[EN_RX] = en_rx_q;
      enable_o[EN_TX] = en_tx_q;
   end

   assign pend_o = (rx_q & en_rx_q) | (tx_q & en_tx_q) | ((|chg_q) & en_ms_q);

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/uirq_group.sv
module uirq_group
   import uart_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 16
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mask_wr_i,
   input  logic              ctrl_wr_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic [NUM_CH-1:0] pend_i,
   output logic [NUM_CH-1:0] mask_o,
   output logic              gen_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mask_q;
   logic              gen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '1;
         gen_q  <= 1'b0;
      end else begin
         if (mask_wr_i) mask_q <= wdata_i[NUM_CH-1:0];
         if (ctrl_wr_i) gen_q  <= wdata_i[CTRL_GEN];
      end
   end

   assign mask_o = mask_q;
   assign gen_o  = gen_q;
   assign irq_o  = gen_q & (|(pend_i & ~mask_q));

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/uart_irq_aggr.sv
module uart_irq_aggr
   import uart_irq_pkg::*;
#(
   parameter  int unsigned NUM_CH      = 16,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned CH_IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned ADDR_W      = CH_IDX_W + 2
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   input  logic [NUM_CH-1:0] rx_evt_i,
   input  logic [NUM_CH-1:0] tx_evt_i,
   input  logic [NUM_CH-1:0] ovr_evt_i,
   input  logic [NUM_CH-1:0] dcd_i,
   input  logic [NUM_CH-1:0] dsr_i,
   input  logic [NUM_CH-1:0] cts_i,
   input  logic [NUM_CH-1:0] ri_i,
   output logic              irq_o
);
   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= REG_W)
         else $fatal(1, "uart_irq_aggr: NUM_CH must be 1..32");
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "uart_irq_aggr: SYNC_STAGES must be at least 2");
   end

   logic                in_grp, sel_en;
   logic [CH_IDX_W-1:0] ch_idx;
   logic [1:0]          grp_sel;

   assign in_grp  = addr_i[ADDR_W-1];
   assign ch_idx  = addr_i[CH_IDX_W:1];
   assign sel_en  = addr_i[0];
   assign grp_sel = addr_i[1:0];

   logic [NUM_CH-1:0][REG_W-1:0] ch_stat, ch_en;
   logic [NUM_CH-1:0]            pend, mask_q;
   logic                         gen_q;
   logic                         mask_wr, ctrl_wr;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit, st_wr, en_wr;
         assign hit   = wr_en_i & ~in_grp & (ch_idx == CH_IDX_W'(c));
         assign st_wr = hit & ~sel_en;
         assign en_wr = hit &  sel_en;

         uirq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .rx_evt_i (rx_evt_i[c]),
            .tx_evt_i (tx_evt_i[c]),
            .ovr_evt_i(ovr_evt_i[c]),
            .line_i   ({ri_i[c], cts_i[c], dsr_i[c], dcd_i[c]}),
            .st_wr_i  (st_wr),
            .en_wr_i  (en_wr),
            .wdata_i  (wdata_i),
            .status_o (ch_stat[c]),
            .enable_o (ch_en[c]),
            .pend_o   (pend[c])
         );
      end
   endgenerate

   assign mask_wr = wr_en_i & in_grp & (grp_sel == GRP_MASK);
   assign ctrl_wr = wr_en_i & in_grp & (grp_sel == GRP_CTRL);

   uirq_group #(.NUM_CH(NUM_CH)) u_group (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mask_wr_i(mask_wr),
      .ctrl_wr_i(ctrl_wr),
      .wdata_i  (wdata_i),
      .pend_i   (pend),
      .mask_o   (mask_q),
      .gen_o    (gen_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (in_grp) begin
         case (grp_sel)
            GRP_PEND: rdata_o = REG_W'(pend);
            GRP_MASK: rdata_o = REG_W'(mask_q);
            GRP_CTRL: rdata_o[CTRL_GEN] = gen_q;
            default:  rdata_o = '0;
         endcase
      end else begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == CH_IDX_W'(k)) rdata_o = sel_en ? ch_en[k] : ch_stat[k];
         end
      end
   end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned CH_IDX_W = 4,
   parameter int unsigned ADDR_W   = 6
)(
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     wr_en_i,
   input logic [ADDR_W-1:0]        addr_i,
   input logic [31:0]              wdata_i,
   input logic [NUM_CH-1:0]        rx_evt_i,
   input logic                     irq_o,
   input logic [NUM_CH-1:0][31:0]  ch_stat,
   input logic [NUM_CH-1:0][31:0]  ch_en,
   input logic [NUM_CH-1:0]        mask_q,
   input logic                     gen_q
);
   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ck
         logic st_wr;
         assign st_wr = wr_en_i && !addr_i[ADDR_W-1] && !addr_i[0]
                        && (addr_i[CH_IDX_W:1] == CH_IDX_W'(c));

         AST_RX_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rx_evt_i[c] |=> ch_stat[c][0]);  // R2
         AST_RX_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_wr && wdata_i[0] && !rx_evt_i[c]) |=> !ch_stat[c][0]);  // R2
         AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ch_stat[c][13] && !(st_wr && wdata_i[13])) |=> ch_stat[c][13]);  // R3
         AST_TXE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ch_en[c][19] |=> !ch_stat[c][25]);  // R6
         AST_EN_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_wr |=> $stable(ch_en[c]));  // R11
      end
   endgenerate

   AST_MASK_ALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask_q) |-> !irq_o);  // R9
   AST_GEN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gen_q |-> !irq_o);  // R10
endmodule

bind uart_irq_aggr uirq_checker #(
   .NUM_CH  (NUM_CH),
   .CH_IDX_W(CH_IDX_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .rx_evt_i(rx_evt_i),
   .irq_o   (irq_o),
   .ch_stat (ch_stat),
   .ch_en   (ch_en),
   .mask_q  (mask_q),
   .gen_q   (gen_q)
);

// File: tb/uart_irq_aggr_test.sv
module uart_irq_aggr_test;
   localparam int NCH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [5:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NCH-1:0] rx_evt = '0, tx_evt = '0, ovr_evt = '0;
   logic [NCH-1:0] dcd = '0, dsr = '0, cts = '0, ri = '0;
   logic irq;

   always #10 clk = ~clk;  // 50 MHz

   uart_irq_aggr #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
      .ovr_evt_i(ovr_evt), .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
      .irq_o(irq)
   );

   // reference model state
   logic [31:0] m_stk [NCH];
   logic [31:0] m_en  [NCH];
   logic [3:0]  m_line[NCH];  // 0 dcd, 1 dsr, 2 cts, 3 ri
   logic [15:0] m_mask;
   logic        m_gen;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   localparam logic [31:0] STICKY = 32'h0247_2001;  // bits 0,13,16,17,18,22,25
   localparam logic [31:0] ENBITS = 32'h0008_0005;

   function automatic logic [5:0] a_stat(int c); return {1'b0, 4'(c), 1'b0}; endfunction
   function automatic logic [5:0] a_en(int c);   return {1'b0, 4'(c), 1'b1}; endfunction
   function automatic logic [5:0] a_grp(int s);  return {1'b1, 3'b000, 2'(s)}; endfunction

   function automatic int chg_bit(int i);
      case (i) 0: return 18; 1: return 16; 2: return 17; default: return 22; endcase
   endfunction

   function automatic logic [31:0] exp_status(int c);
      return m_stk[c] | (32'(m_line[c]) << 3);
   endfunction

   function automatic logic exp_pend(int c);
      logic anychg;
      anychg = m_stk[c][16] | m_stk[c][17] | m_stk[c][18] | m_stk[c][22];
      return (m_stk[c][0] & m_en[c][2]) | (m_stk[c][25] & m_en[c][19]) | (anychg & m_en[c][0]);
   endfunction

   function automatic logic [15:0] exp_pvec();
      logic [15:0] v;
      for (int c = 0; c < NCH; c++) v[c] = exp_pend(c);
      return v;
   endfunction

   function automatic logic exp_irq();
      return m_gen & (|(exp_pvec() & ~m_mask));
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr_stat(int c, logic [31:0] d);
      wr(a_stat(c), d);
      m_stk[c] = m_stk[c] & ~(d & STICKY);
   endtask

   task automatic wr_enab(int c, logic [31:0] d);
      wr(a_en(c), d);
      m_en[c] = d & ENBITS;
      if (!d[19]) m_stk[c][25] = 1'b0;
   endtask

   task automatic wr_mask(logic [31:0] d);
      wr(a_grp(1), d);
      m_mask = d[15:0];
   endtask

   task automatic wr_ctrl(logic [31:0] d);
      wr(a_grp(2), d);
      m_gen = d[20];
   endtask

   // kind 0 rx, 1 overrun, 2 tx-empty
   task automatic pulse(int kind, int c);
      @(negedge clk);
      case (kind)
         0: rx_evt[c] = 1'b1;
         1: ovr_evt[c] = 1'b1;
         default: tx_evt[c] = 1'b1;
      endcase
      @(negedge clk);
      rx_evt = '0; ovr_evt = '0; tx_evt = '0;
      repeat (2) @(negedge clk);
      case (kind)
         0: m_stk[c][0] = 1'b1;
         1: m_stk[c][13] = 1'b1;
         default: if (m_en[c][19]) m_stk[c][25] = 1'b1;
      endcase
   endtask

   task automatic toggle(int c, int i);
      @(negedge clk);
      case (i)
         0: dcd[c] = ~dcd[c];
         1: dsr[c] = ~dsr[c];
         2: cts[c] = ~cts[c];
         default: ri[c] = ~ri[c];
      endcase
      repeat (5) @(negedge clk);
      m_line[c][i] = ~m_line[c][i];
      m_stk[c][chg_bit(i)] = 1'b1;
   endtask

   task automatic check_ch(int c, string req);
      logic [31:0] v;
      rd(a_stat(c), v); chk({req, " status"}, v, exp_status(c));
      rd(a_en(c), v);   chk({req, " enable"}, v, m_en[c]);
      rd(a_grp(0), v);  chk({req, " pending"}, v, {16'h0, exp_pvec()});
      chk({req, " irq"}, {31'h0, irq}, {31'h0, exp_irq()});
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0042));
      for (int c = 0; c < NCH; c++) begin
         m_stk[c] = '0; m_en[c] = '0; m_line[c] = '0;
      end
      m_mask = 16'hFFFF; m_gen = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      for (int c = 0; c < NCH; c++) begin
         rd(a_stat(c), v); chk("R1 status after reset", v, 32'h0);
         rd(a_en(c), v);   chk("R1 enable after reset", v, 32'h0);
      end
      rd(a_grp(1), v); chk("R1 mask after reset", v, 32'h0000_FFFF);
      rd(a_grp(2), v); chk("R1 control after reset", v, 32'h0);
      chk("R1 irq after reset", {31'h0, irq}, 32'h0);

      // R7 enable implements only bits 0, 2, 19
      wr_enab(0, 32'hFFFF_FFFF);
      rd(a_en(0), v); chk("R7 enable readback", v, 32'h0008_0005);

      // R2/R8/R9/R10 receive path to irq
      pulse(0, 0);
      check_ch(0, "R2 rx set");
      chk("R9 masked channel keeps irq low", {31'h0, irq}, 32'h0);
      wr_mask(32'h0000_FFFE);
      chk("R10 group enable off keeps irq low", {31'h0, irq}, 32'h0);
      wr_ctrl(32'h0010_0000);
      check_ch(0, "R10 irq on");
      wr_ctrl(32'hFFEF_FFFF);
      check_ch(0, "R10 other control bits");
      wr_ctrl(32'h0010_0000);

      // R2 set and clear in the same cycle: set wins
      @(negedge clk);
      rx_evt[0] = 1'b1; wr_en = 1'b1; addr = a_stat(0); wdata = 32'h1;
      @(negedge clk);
      rx_evt = '0; wr_en = 1'b0; wdata = '0;
      repeat (2) @(negedge clk);
      check_ch(0, "R2 set wins");
      wr_stat(0, 32'h1);
      check_ch(0, "R2 W1C clears");

      // R3 overrun is sticky but not a cause
      pulse(1, 0);
      check_ch(0, "R3 overrun");
      wr_stat(0, 32'h0000_2000);
      check_ch(0, "R3 overrun cleared");

      // R6 transmit empty gating
      wr_mask(32'h0);
      wr_enab(1, 32'h0);
      pulse(2, 1);
      check_ch(1, "R6 tx ignored when disabled");
      wr_enab(1, 32'h0008_0000);
      pulse(2, 1);
      check_ch(1, "R6 tx set when enabled");
      wr_enab(1, 32'h0);
      check_ch(1, "R6 disable clears tx");
      wr_enab(1, 32'h0008_0000);
      check_ch(1, "R6 re-enable stays clear");

      // R4/R5 modem lines
      wr_enab(2, 32'h1);
      toggle(2, 2);
      check_ch(2, "R5 cts rise");
      toggle(2, 2);
      check_ch(2, "R5 cts fall");
      wr_stat(2, 32'h0002_0000);
      check_ch(2, "R5 cts change cleared");
      toggle(2, 0);
      toggle(2, 3);
      check_ch(2, "R4 dcd and ri live");
      wr_stat(2, 32'hFFFF_FFFF);
      check_ch(2, "R4 live bits ignore writes");

      // R11 address map corners
      wr(a_grp(0), 32'h0);
      rd(a_grp(0), v); chk("R11 pending write ignored", v, {16'h0, exp_pvec()});
      rd(a_grp(3), v); chk("R11 unused group word", v, 32'h0);

      // random phase
      for (int it = 0; it < 500; it++) begin
         int c, op;
         c  = int'($urandom % NCH);
         op = int'($urandom % 9);
         case (op)
            0: begin pulse(0, c); check_ch(c, "R2 random rx"); end
            1: begin pulse(1, c); check_ch(c, "R3 random overrun"); end
            2: begin pulse(2, c); check_ch(c, "R6 random tx"); end
            3: begin toggle(c, int'($urandom % 4)); check_ch(c, "R5 random line"); end
            4: begin wr_enab(c, $urandom); check_ch(c, "R7 random enable"); end
            5: begin wr_stat(c, $urandom); check_ch(c, "R4 random clear"); end
            6: begin wr_mask($urandom); check_ch(c, "R9 random mask"); end
            7: begin wr_ctrl($urandom); check_ch(c, "R10 random control"); end
            default: begin wr(a_grp(0), $urandom); check_ch(c, "R8 random pending write"); end
         endcase
      end

      done = 1;
      summary();
      $finish;
   end
endmodule